// File: doc/BRIEF.md
# Multi-Port Transmit Bus Steering Receiver

This block sits on the receive side of a shared 32-bit packet transmit bus that serves several ports. The bus carries two kinds of cycle. In a port-select cycle the bus picks which port owns the words that follow, and the port number travels on the low data bits. In a data cycle one packet word is carried. The block remembers the most recently selected port. It turns each data word into a one-cycle write strobe for that port's FIFO, together with the word itself, byte-valid enables, packet start and end flags and the sender's error flag.

All inputs are sampled on the rising clock edge. Every output is registered and appears one cycle after the edge that sampled the inputs. A separate one-cycle protocol error pulse reports two kinds of misuse: a data word that arrives while no port is selected, and a nonzero byte-count code on a word that does not end a packet.

Top module: `txbus_port_steer`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, clears the selection to "no port". It also leaves every write strobe and flag output at zero in the cycle after that edge.
- R2: When `busEnN` is high and `addrCyc` is high, the cycle selects port `busData[1:0]`. No other data bit affects the selection, and the cycle writes nothing.
- R3: When `busEnN` is low, `addrCyc` is ignored and the cycle is handled as a data word for the current port.
- R4: A data word (`busEnN` low) arriving while a port is selected gives a one-cycle strobe on `portWr[p]` only, where p is the selected port. `wrData` carries the word, one cycle after the sampling edge.
- R5: The selected port keeps its value across any number of data words until the next port-select cycle.
- R6: On a word with `pktEnd` high, `wrByteEn` follows `modCode`. Bit 3 of `wrByteEn` covers `busData[31:24]` and bit 0 covers `[7:0]`. The codes map as 00→1111, 01→1110, 10→1100 and 11→1000.
- R7: On a data word without `pktEnd`, all four byte enables are set. If `modCode` is nonzero on such a word, `protoErr` pulses and the word is still written.
- R8: A data word that arrives while no port is selected writes to no port and pulses `protoErr`.
- R9: `wrSop`, `wrEop` and `wrErr` repeat `pktStart`, `pktEnd` and `errIn` of the written word. In cycles with no write strobe, these flags and `wrByteEn` are all zero.
- R10: An idle cycle, with `busEnN` high and `addrCyc` low, writes nothing and raises no error, whatever the other inputs are. It also leaves the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| busEnN | input | 1 | Low marks a data word |
| addrCyc | input | 1 | With busEnN high, marks a port-select cycle |
| pktStart | input | 1 | Word is the first of a packet |
| pktEnd | input | 1 | Word is the last of a packet |
| modCode | input | 2 | Valid-byte code for the last word |
| errIn | input | 1 | Sender marks the packet as errored |
| busData | input | 32 | Packet word, or port number in bits [1:0] |
| portWr | output | 4 | One-hot write strobe, one bit per port |
| wrData | output | 32 | Word being written |
| wrByteEn | output | 4 | Byte enables, bit 3 covers [31:24] |
| wrSop | output | 1 | Start-of-packet flag of the written word |
| wrEop | output | 1 | End-of-packet flag of the written word |
| wrErr | output | 1 | Error flag of the written word |
| protoErr | output | 1 | One-cycle protocol misuse pulse |

## Verification
The steering path is exercised by port-select cycles whose upper data bits are all ones, which shows that only the two low bits pick the port. Data words are also sent with the select marker raised, which separates "marker ignored during data" from "marker always decodes". Every port is visited, and every end-of-packet code is checked, so a swapped or reversed byte-enable mapping gives a wrong pattern. Idle cycles carry nonzero flags and codes, followed by a data word; this catches both spurious writes and a selection disturbed by the idle cycle. A reset in the middle of a stream, followed by a data word, shows that reset forgets the selection.

// File: rtl/txsteer_pkg.sv
package txsteer_pkg;
  // Strobes from control to datapath, valid in the sampling cycle
  typedef struct packed {
    logic wrEn;      // write the current word to the selected port
    logic lastWord;  // word ends a packet, byte-count code applies
    logic protoErr;  // protocol misuse seen on this cycle
  } steerCtl_t;
endpackage

// File: rtl/txsteer_ctrl.sv
module txsteer_ctrl
  import txsteer_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int BYTES     = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int MOD_W    = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busEnN,
  input  logic              addrCyc,
  input  logic              pktEnd,
  input  logic [MOD_W-1:0]  modCode,
  input  logic [PORT_W-1:0] addrBits,
  output steerCtl_t         ctl,
  output logic [PORT_W-1:0] selPort
);
  logic selValid;
  logic isAddr;
  logic isData;
  logic addrLegal;

  assign isAddr    = busEnN & addrCyc;
  assign isData    = ~busEnN;
  assign addrLegal = ({1'b0, addrBits} < (PORT_W+1)'(NUM_PORTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      selValid <= 1'b0;
      selPort  <= '0;
    end else if (isAddr) begin
      selValid <= addrLegal;
      selPort  <= addrBits;
    end
  end

  always_comb begin
    ctl.wrEn     = isData & selValid;
    ctl.lastWord = pktEnd;
    ctl.protoErr = isData & (~selValid | ((modCode != '0) & ~pktEnd));
  end

  // selection only moves on a port-select cycle
  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(busEnN && addrCyc) |=> ($stable(selPort) && $stable(selValid)));

  // a port-select cycle always leaves some port chosen
  assert_sel_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (busEnN && addrCyc && addrLegal) |=> (selValid && selPort == $past(addrBits)));
endmodule

// File: rtl/txsteer_dpath.sv
module txsteer_dpath
  import txsteer_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  localparam int BYTES    = DATA_W / 8,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int MOD_W    = $clog2(BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  steerCtl_t            ctl,
  input  logic [PORT_W-1:0]    selPort,
  input  logic [MOD_W-1:0]     modCode,
  input  logic                 pktStart,
  input  logic                 pktEnd,
  input  logic                 errIn,
  input  logic [DATA_W-1:0]    busData,
  output logic [NUM_PORTS-1:0] portWr,
  output logic [DATA_W-1:0]    wrData,
  output logic [BYTES-1:0]     wrByteEn,
  output logic                 wrSop,
  output logic                 wrEop,
  output logic                 wrErr,
  output logic                 protoErr
);
  logic [NUM_PORTS-1:0] portWrNext;
  logic [BYTES-1:0]     byteEnNext;

  // one strobe bit per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    assign portWrNext[p] = ctl.wrEn & (selPort == PORT_W'(p));
  end

  // bytes fill from the top: byte i is valid when i >= code
  for (genvar i = 0; i < BYTES; i++) begin : gByte
    assign byteEnNext[i] = ~ctl.lastWord | (modCode <= MOD_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      portWr   <= '0;
      wrData   <= '0;
      wrByteEn <= '0;
      wrSop    <= 1'b0;
      wrEop    <= 1'b0;
      wrErr    <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      portWr   <= portWrNext;
      protoErr <= ctl.protoErr;
      if (ctl.wrEn) begin
        wrData   <= busData;
        wrByteEn <= byteEnNext;
        wrSop    <= pktStart;
        wrEop    <= pktEnd;
        wrErr    <= errIn;
      end else begin
        wrByteEn <= '0;
        wrSop    <= 1'b0;
        wrEop    <= 1'b0;
        wrErr    <= 1'b0;
      end
    end
  end

  assert_onehot_wr_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(portWr));

  // every legal code keeps the top byte valid
  assert_be_msb_R6: assert property (@(posedge clk) disable iff (rst)
    (portWr != '0) |-> wrByteEn[BYTES-1]);
endmodule

// File: rtl/txbus_port_steer.sv
module txbus_port_steer
  import txsteer_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  localparam int BYTES    = DATA_W / 8,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int MOD_W    = $clog2(BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busEnN,
  input  logic                 addrCyc,
  input  logic                 pktStart,
  input  logic                 pktEnd,
  input  logic [MOD_W-1:0]     modCode,
  input  logic                 errIn,
  input  logic [DATA_W-1:0]    busData,
  output logic [NUM_PORTS-1:0] portWr,
  output logic [DATA_W-1:0]    wrData,
  output logic [BYTES-1:0]     wrByteEn,
  output logic                 wrSop,
  output logic                 wrEop,
  output logic                 wrErr,
  output logic                 protoErr
);
  steerCtl_t         ctl;
  logic [PORT_W-1:0] selPort;

  txsteer_ctrl #(.NUM_PORTS(NUM_PORTS), .BYTES(BYTES)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .busEnN   (busEnN),
    .addrCyc  (addrCyc),
    .pktEnd   (pktEnd),
    .modCode  (modCode),
    .addrBits (busData[PORT_W-1:0]),
    .ctl      (ctl),
    .selPort  (selPort)
  );

  txsteer_dpath #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .selPort  (selPort),
    .modCode  (modCode),
    .pktStart (pktStart),
    .pktEnd   (pktEnd),
    .errIn    (errIn),
    .busData  (busData),
    .portWr   (portWr),
    .wrData   (wrData),
    .wrByteEn (wrByteEn),
    .wrSop    (wrSop),
    .wrEop    (wrEop),
    .wrErr    (wrErr),
    .protoErr (protoErr)
  );

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (busEnN && !addrCyc) |=> (portWr == '0 && !protoErr));

  assert_addr_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
    busEnN |=> (portWr == '0));

  assert_flags_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (portWr == '0) |-> (wrByteEn == '0 && !wrSop && !wrEop && !wrErr));

  assert_data_copy_R4: assert property (@(posedge clk) disable iff (rst)
    !busEnN |=> (portWr == '0 || wrData == $past(busData)));

  assert_midword_full_R7: assert property (@(posedge clk) disable iff (rst)
    (!busEnN && !pktEnd) |=> (portWr == '0 || wrByteEn == '1));
endmodule

// File: tb/tb_txbus_port_steer.sv
module tb_txbus_port_steer;
  logic        clk = 1'b0;
  logic        rst;
  logic        busEnN, addrCyc, pktStart, pktEnd, errIn;
  logic [1:0]  modCode;
  logic [31:0] busData;
  logic [3:0]  portWr, wrByteEn;
  logic [31:0] wrData;
  logic        wrSop, wrEop, wrErr, protoErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  txbus_port_steer dut (
    .clk(clk), .rst(rst), .busEnN(busEnN), .addrCyc(addrCyc),
    .pktStart(pktStart), .pktEnd(pktEnd), .modCode(modCode), .errIn(errIn),
    .busData(busData), .portWr(portWr), .wrData(wrData), .wrByteEn(wrByteEn),
    .wrSop(wrSop), .wrEop(wrEop), .wrErr(wrErr), .protoErr(protoErr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Layout: req[54:51] enN addr sop eop mod[46:45] err data[43:12]
  //         expWr[11:8] expBe[7:4] expSop expEop expErr expPerr
  localparam int NV = 16;
  localparam logic [54:0] VEC [NV] = '{
    {4'd8,  1'b0,1'b0,1'b0,1'b0,2'b00,1'b0, 32'hA5A5_0001, 4'b0000,4'b0000, 1'b0,1'b0,1'b0,1'b1}, // R8 no port yet
    {4'd2,  1'b1,1'b1,1'b0,1'b0,2'b00,1'b0, 32'hFFFF_FFF6, 4'b0000,4'b0000, 1'b0,1'b0,1'b0,1'b0}, // R2 select 2
    {4'd4,  1'b0,1'b0,1'b1,1'b0,2'b00,1'b0, 32'h1111_2222, 4'b0100,4'b1111, 1'b1,1'b0,1'b0,1'b0}, // R4
    {4'd3,  1'b0,1'b1,1'b0,1'b0,2'b00,1'b0, 32'h0000_0001, 4'b0100,4'b1111, 1'b0,1'b0,1'b0,1'b0}, // R3
    {4'd6,  1'b0,1'b0,1'b0,1'b1,2'b01,1'b0, 32'h3333_4444, 4'b0100,4'b1110, 1'b0,1'b1,1'b0,1'b0}, // R6 code 01
    {4'd10, 1'b1,1'b0,1'b1,1'b1,2'b11,1'b1, 32'h0000_0003, 4'b0000,4'b0000, 1'b0,1'b0,1'b0,1'b0}, // R10 idle
    {4'd5,  1'b0,1'b0,1'b0,1'b1,2'b00,1'b0, 32'h5555_6666, 4'b0100,4'b1111, 1'b0,1'b1,1'b0,1'b0}, // R5 / R6 code 00
    {4'd2,  1'b1,1'b1,1'b0,1'b0,2'b00,1'b0, 32'h1234_5670, 4'b0000,4'b0000, 1'b0,1'b0,1'b0,1'b0}, // R2 select 0
    {4'd6,  1'b0,1'b0,1'b1,1'b1,2'b10,1'b1, 32'h7777_8888, 4'b0001,4'b1100, 1'b1,1'b1,1'b1,1'b0}, // R6 code 10, R9
    {4'd2,  1'b1,1'b1,1'b0,1'b0,2'b00,1'b0, 32'h0000_0003, 4'b0000,4'b0000, 1'b0,1'b0,1'b0,1'b0}, // R2 select 3
    {4'd6,  1'b0,1'b0,1'b0,1'b1,2'b11,1'b0, 32'h9999_AAAA, 4'b1000,4'b1000, 1'b0,1'b1,1'b0,1'b0}, // R6 code 11
    {4'd7,  1'b0,1'b0,1'b0,1'b0,2'b10,1'b0, 32'hBBBB_CCCC, 4'b1000,4'b1111, 1'b0,1'b0,1'b0,1'b1}, // R7
    {4'd2,  1'b1,1'b1,1'b0,1'b0,2'b00,1'b0, 32'h0000_0005, 4'b0000,4'b0000, 1'b0,1'b0,1'b0,1'b0}, // R2 select 1
    {4'd9,  1'b0,1'b0,1'b1,1'b1,2'b11,1'b1, 32'hDDDD_EEEE, 4'b0010,4'b1000, 1'b1,1'b1,1'b1,1'b0}, // R9
    {4'd10, 1'b1,1'b0,1'b0,1'b0,2'b00,1'b0, 32'hFFFF_FFFE, 4'b0000,4'b0000, 1'b0,1'b0,1'b0,1'b0}, // R10 idle
    {4'd10, 1'b0,1'b0,1'b0,1'b0,2'b00,1'b0, 32'h0BAD_F00D, 4'b0010,4'b1111, 1'b0,1'b0,1'b0,1'b0}  // R10 port kept
  };

  task automatic drive(input logic enN, addr, sop, eop, input logic [1:0] mod,
                       input logic err, input logic [31:0] data);
    busEnN = enN; addrCyc = addr; pktStart = sop; pktEnd = eop;
    modCode = mod; errIn = err; busData = data;
  endtask

  task automatic checkAll(input string req, input logic [3:0] eWr, input logic [3:0] eBe,
                          input logic eS, eE, eR, eP, input logic [31:0] eD);
    chk(req, "portWr", 32'(portWr), 32'(eWr));
    chk(req, "wrByteEn", 32'(wrByteEn), 32'(eBe));
    chk(req, "wrSop", 32'(wrSop), 32'(eS));
    chk(req, "wrEop", 32'(wrEop), 32'(eE));
    chk(req, "wrErr", 32'(wrErr), 32'(eR));
    chk(req, "protoErr", 32'(protoErr), 32'(eP));
    if (eWr != 4'b0000) chk(req, "wrData", wrData, eD);
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    // R1: outputs quiet after reset
    checkAll("R1", 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [54:0] v;
      v = VEC[k];
      drive(v[50], v[49], v[48], v[47], v[46:45], v[44], v[43:12]);
      @(negedge clk);
      checkAll($sformatf("R%0d vec%0d", v[54:51], k), v[11:8], v[7:4],
               v[3], v[2], v[1], v[0], v[43:12]);
    end

    // R1: reset mid-stream forgets the selected port
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_0002);
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    checkAll("R1 reset", 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 32'hCAFE_0000);
    @(negedge clk);
    checkAll("R1 after reset", 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);

    // R3: select marker on a data word must not reselect to port 3
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_0000);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_0003);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 32'h4242_4242);
    @(negedge clk);
    checkAll("R3 stays port0", 4'b0001, 4'b1111, 1'b0, 1'b1, 1'b0, 1'b0, 32'h4242_4242);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule